// File: doc/BRIEF.md
# Parallel Integer Multiply-Store Unit

This block executes one combined instruction in a single clock cycle. A signed integer multiply takes one data register and one word read from internal memory, and puts the result into a destination data register. In the same cycle a second data register is written out to internal memory. The unit holds eight 32-bit data registers, eight auxiliary address registers, two index registers and a 256-word data memory. Both memory addresses are indirect. Each is an auxiliary register plus a displacement of zero, one, or one of the two index registers.

Every operand is read at the start of the cycle and every result is committed at the clock edge that ends it. A store whose source is the register the multiply overwrites therefore writes the old register value. A multiply whose memory operand sits at the address the store writes therefore reads the old memory word. A registered overflow flag reports a product that does not fit in 32 bits.

A load port presets the registers and memory while no instruction is issued. Two combinational peek ports read back one data register and one memory word. The unit has no state machine: one issue strobe commits everything at a single edge.

Top module: `mst_core`

## Requirements
- R1: On an issue cycle, the destination data register receives bits 31:0 of the product of the low 24 bits of the source data register and the low 24 bits of the memory operand, each taken as two's-complement. Bits 31:24 of both operands are ignored.
- R2: Overflow is computed as true when any of product bits 47:32 differs from product bit 31.
- R3: The overflow output is registered and resets to 0. It is updated only at the end of an issue cycle and holds its value on every other cycle.
- R4: On an issue cycle, the store source data register is written to memory at the write address.
- R5: Each address is the low 8 bits of the selected auxiliary register plus a displacement. The displacement code is 0 for +0, 1 for +1, 2 for index register 0 and 3 for index register 1. The sum wraps modulo 256.
- R6: When the store source register is also the multiply destination, memory receives the value that register held before the cycle.
- R7: When the read address equals the write address, the multiply uses the memory word as it was before the cycle.
- R8: A load with `ld_en` high and `issue` low writes `ld_data` at the next edge. The space code is 0 for data register idx[2:0], 1 for auxiliary register idx[2:0], 2 for index register idx[0], and 3 for memory word idx. A load presented together with `issue` is ignored.
- R9: Reset clears all data, auxiliary and index registers.
- R10: `peek_reg_data` shows data register `peek_reg` and `peek_mem_data` shows memory word `peek_addr`, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Execute the multiply-store this cycle |
| mul_src | input | 3 | Multiply source data register |
| mul_dst | input | 3 | Multiply destination data register |
| st_src | input | 3 | Store source data register |
| rd_ar | input | 3 | Auxiliary register for the read address |
| rd_disp | input | 2 | Displacement code for the read address |
| wr_ar | input | 3 | Auxiliary register for the write address |
| wr_disp | input | 2 | Displacement code for the write address |
| ld_en | input | 1 | Preset load strobe |
| ld_space | input | 2 | Load target space |
| ld_idx | input | 8 | Load target index or memory address |
| ld_data | input | 32 | Load value |
| peek_reg | input | 3 | Data register to observe |
| peek_reg_data | output | 32 | Value of the observed data register |
| peek_addr | input | 8 | Memory word to observe |
| peek_mem_data | output | 32 | Value of the observed memory word |
| ovf | output | 1 | Registered overflow flag |

## Verification
A wrong address sum or a wrong displacement decode leaves the stored word at an unexpected memory location. A wrong commit order shows up in two ways: a swapped register value in memory, or a product built from an already-updated memory word. Each of these is visible on the peek ports in the cycle right after the issue edge. A flag that updates when it should hold can be seen on `ovf` one edge after an idle cycle. The stimulus therefore pairs every issue with an immediate readback of the destination register, the store target and the flag.

// File: rtl/mst_pkg.sv
package mst_pkg;
    typedef enum logic [1:0] {
        DISP_ZERO = 2'd0,
        DISP_ONE  = 2'd1,
        DISP_IX0  = 2'd2,
        DISP_IX1  = 2'd3
    } disp_e;

    typedef enum logic [1:0] {
        SP_DATA  = 2'd0,
        SP_AUX   = 2'd1,
        SP_INDEX = 2'd2,
        SP_MEM   = 2'd3
    } space_e;
endpackage

// File: rtl/mst_agen.sv
module mst_agen
    import mst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ix0,
    input  logic [AW-1:0] ix1,
    input  logic [1:0]    disp,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] offset;

    always_comb begin
        unique case (disp_e'(disp))
            DISP_ZERO: offset = '0;
            DISP_ONE:  offset = AW'(1);
            DISP_IX0:  offset = ix0;
            DISP_IX1:  offset = ix1;
            default:   offset = '0;
        endcase
        addr = base + offset;
    end
endmodule

// File: rtl/mst_mul.sv
module mst_mul #(
    parameter int DW    = 32,
    parameter int MUL_W = 24
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] result,
    output logic          overflow
);
    localparam int PW = 2 * MUL_W;

    logic signed [PW-1:0] ext_a, ext_b, prod;

    always_comb begin
        ext_a    = PW'($signed(op_a[MUL_W-1:0]));
        ext_b    = PW'($signed(op_b[MUL_W-1:0]));
        prod     = ext_a * ext_b;
        result   = prod[DW-1:0];
        overflow = (prod[PW-1:DW] != {(PW-DW){prod[DW-1]}});
    end
endmodule

// File: rtl/mst_dmem.sv
module mst_dmem #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[raddr];
    assign pdata = mem[paddr];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // R4 / R8: a write lands at the addressed word by the next edge
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mst_core.sv
module mst_core
    import mst_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 8,
    parameter int NAUX  = 8,
    parameter int AW    = 8,
    parameter int MUL_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic [$clog2(NREG)-1:0]  mul_src,
    input  logic [$clog2(NREG)-1:0]  mul_dst,
    input  logic [$clog2(NREG)-1:0]  st_src,
    input  logic [$clog2(NAUX)-1:0]  rd_ar,
    input  logic [1:0]               rd_disp,
    input  logic [$clog2(NAUX)-1:0]  wr_ar,
    input  logic [1:0]               wr_disp,
    input  logic                     ld_en,
    input  logic [1:0]               ld_space,
    input  logic [AW-1:0]            ld_idx,
    input  logic [DW-1:0]            ld_data,
    input  logic [$clog2(NREG)-1:0]  peek_reg,
    output logic [DW-1:0]            peek_reg_data,
    input  logic [AW-1:0]            peek_addr,
    output logic [DW-1:0]            peek_mem_data,
    output logic                     ovf
);
    localparam int RIW = $clog2(NREG);
    localparam int AIW = $clog2(NAUX);
    localparam int NPORT = 2;   // index 0: multiply read, 1: store write

    logic [NREG-1:0][DW-1:0] rf_q;
    logic [NAUX-1:0][AW-1:0] ar_q;
    logic [AW-1:0]           ix_q [2];
    logic                    ovf_q;

    logic [AIW-1:0] port_ar   [NPORT];
    logic [1:0]     port_disp [NPORT];
    logic [AW-1:0]  port_addr [NPORT];

    logic [DW-1:0]  mem_rdata, mul_res, st_data;
    logic           mul_ovf;
    logic           ld_ok, mem_we;
    logic [AW-1:0]  mem_waddr;
    logic [DW-1:0]  mem_wdata;

    assign port_ar[0]   = rd_ar;
    assign port_disp[0] = rd_disp;
    assign port_ar[1]   = wr_ar;
    assign port_disp[1] = wr_disp;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_agen
            mst_agen #(.AW(AW)) u_agen (
                .base (ar_q[port_ar[g]]),
                .ix0  (ix_q[0]),
                .ix1  (ix_q[1]),
                .disp (port_disp[g]),
                .addr (port_addr[g])
            );
        end
    endgenerate

    mst_mul #(.DW(DW), .MUL_W(MUL_W)) u_mul (
        .op_a     (rf_q[mul_src]),
        .op_b     (mem_rdata),
        .result   (mul_res),
        .overflow (mul_ovf)
    );

    // Old register contents feed the store: read before commit
    assign st_data = rf_q[st_src];
    assign ld_ok   = ld_en && !issue;

    always_comb begin
        mem_we    = issue || (ld_ok && space_e'(ld_space) == SP_MEM);
        mem_waddr = issue ? port_addr[1] : ld_idx;
        mem_wdata = issue ? st_data      : ld_data;
    end

    mst_dmem #(.DW(DW), .AW(AW)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (port_addr[0]),
        .rdata (mem_rdata),
        .paddr (peek_addr),
        .pdata (peek_mem_data),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q    <= '0;
            ar_q    <= '0;
            ix_q[0] <= '0;
            ix_q[1] <= '0;
            ovf_q   <= 1'b0;
        end else if (issue) begin
            rf_q[mul_dst] <= mul_res;
            ovf_q         <= mul_ovf;
        end else if (ld_en) begin
            unique case (space_e'(ld_space))
                SP_DATA:  rf_q[ld_idx[RIW-1:0]] <= ld_data;
                SP_AUX:   ar_q[ld_idx[AIW-1:0]] <= ld_data[AW-1:0];
                SP_INDEX: ix_q[ld_idx[0]]       <= ld_data[AW-1:0];
                SP_MEM:   ;
                default:  ;
            endcase
        end
    end

    assign ovf           = ovf_q;
    assign peek_reg_data = rf_q[peek_reg];

    // R1: destination takes the multiplier result at the issue edge
    p_dst_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> rf_q[$past(mul_dst)] == $past(mul_res));

    // R3: flag holds on cycles without issue
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(ovf_q));

    // R8: no register changes without an issue or a load
    p_regs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !ld_en) |=> ($stable(rf_q) && $stable(ar_q)));

    // R8: a data load alongside an issue is dropped
    p_load_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ld_en && ld_space == 2'd0 && ld_idx[RIW-1:0] != mul_dst)
        |=> rf_q[$past(ld_idx[RIW-1:0])] == $past(rf_q[ld_idx[RIW-1:0]]));

    // R6: store source data is the pre-commit register value
    p_store_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> mem_wdata == rf_q[st_src]);
endmodule

// File: tb/sim_mst_core.sv
module sim_mst_core;
    localparam int CLK_P = 10;
    localparam int NV = 8;
    localparam logic [31:0] VEC_A [NV] = '{
        32'h0000_0001, 32'h007F_FFFF, 32'h00FF_FFFF, 32'h0001_0000,
        32'h0000_FFFF, 32'h00FF_0000, 32'hAB00_0005, 32'h0080_0000 };
    localparam logic [31:0] VEC_B [NV] = '{
        32'h0000_0002, 32'h007F_FFFF, 32'h00FF_FFFF, 32'h0000_8000,
        32'h0000_7FFF, 32'h0000_8000, 32'h7700_0003, 32'h0000_0001 };

    logic clk = 0, rst_n = 0, issue = 0, ld_en = 0, ovf;
    logic [2:0] mul_src = 0, mul_dst = 0, st_src = 0, rd_ar = 0, wr_ar = 0, peek_reg = 0;
    logic [1:0] rd_disp = 0, wr_disp = 0, ld_space = 0;
    logic [7:0] ld_idx = 0, peek_addr = 0;
    logic [31:0] ld_data = 0, peek_reg_data, peek_mem_data;
    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    mst_core u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [1:0] sp, logic [7:0] idx, logic [31:0] d);
        ld_en = 1; ld_space = sp; ld_idx = idx; ld_data = d;
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic run(logic [2:0] ms, logic [2:0] md, logic [2:0] ss,
                       logic [2:0] ra, logic [1:0] rdp, logic [2:0] wa, logic [1:0] wdp);
        issue = 1; mul_src = ms; mul_dst = md; st_src = ss;
        rd_ar = ra; rd_disp = rdp; wr_ar = wa; wr_disp = wdp;
        @(negedge clk);
        issue = 0;
    endtask

    function automatic logic [31:0] rd_reg(logic [2:0] r);
        peek_reg = r;
        return peek_reg_data;
    endfunction

    task automatic peek_r(logic [2:0] r, output logic [31:0] v);
        peek_reg = r; #1 v = peek_reg_data;
    endtask

    task automatic peek_m(logic [7:0] a, output logic [31:0] v);
        peek_addr = a; #1 v = peek_mem_data;
    endtask

    function automatic logic [47:0] ref_prod(logic [31:0] a, logic [31:0] b);
        logic signed [47:0] sa, sb;
        sa = {{24{a[23]}}, a[23:0]};
        sb = {{24{b[23]}}, b[23:0]};
        return sa * sb;
    endfunction

    function automatic logic ref_ovf(logic [47:0] p);
        return p[47:32] != {16{p[31]}};
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [31:0] v, stv;
        logic [47:0] p;
        @(negedge clk); @(negedge clk);
        // R9 / R3: reset state
        chk("R3 reset ovf", {31'b0, ovf}, 0);
        for (int r = 0; r < 8; r++) begin
            peek_r(r[2:0], v);
            chk("R9 reset reg", v, 0);
        end
        rst_n = 1;
        @(negedge clk);

        // Vector table: R1 R2 R4 R10
        for (int i = 0; i < NV; i++) begin
            stv = VEC_A[i] ^ 32'h5A5A_0F0F;
            load(2'd0, 8'd1, VEC_A[i]);
            load(2'd0, 8'd2, stv);
            load(2'd1, 8'd0, 32'h10 + i);
            load(2'd1, 8'd1, 32'h40 + i);
            load(2'd3, 8'(8'h10 + i), VEC_B[i]);
            run(3'd1, 3'd3, 3'd2, 3'd0, 2'd0, 3'd1, 2'd1);
            p = ref_prod(VEC_A[i], VEC_B[i]);
            peek_r(3'd3, v);
            chk("R1 product", v, p[31:0]);
            chk("R2 overflow", {31'b0, ovf}, {31'b0, ref_ovf(p)});
            peek_m(8'(8'h41 + i), v);
            chk("R4 store", v, stv);
        end

        // R3: flag holds while idle (last vector: 0x800000*1, no overflow; set one first)
        load(2'd0, 8'd1, 32'h007F_FFFF);
        load(2'd1, 8'd0, 32'h11);   // memory 0x11 holds 0x7FFFFF
        run(3'd1, 3'd3, 3'd2, 3'd0, 2'd0, 3'd1, 2'd1);
        repeat (3) @(negedge clk);
        chk("R3 hold", {31'b0, ovf}, 1);
        load(2'd0, 8'd1, 32'd0);    // load cycle must not touch flag
        chk("R3 hold on load", {31'b0, ovf}, 1);

        // R6: store source equals multiply destination
        load(2'd0, 8'd4, 32'h0000_1111);
        load(2'd1, 8'd0, 32'h60);
        load(2'd1, 8'd1, 32'h70);
        load(2'd3, 8'h60, 32'd5);
        run(3'd4, 3'd4, 3'd4, 3'd0, 2'd0, 3'd1, 2'd0);
        peek_r(3'd4, v);
        chk("R6 dst updated", v, 32'h0000_5555);
        peek_m(8'h70, v);
        chk("R6 old value stored", v, 32'h0000_1111);
        chk("R3 cleared on issue", {31'b0, ovf}, 0);

        // R7: read and write at the same address
        load(2'd0, 8'd1, 32'd3);
        load(2'd0, 8'd2, 32'h99);
        load(2'd1, 8'd0, 32'h20);
        load(2'd1, 8'd1, 32'h20);
        load(2'd3, 8'h20, 32'd7);
        run(3'd1, 3'd3, 3'd2, 3'd0, 2'd0, 3'd1, 2'd0);
        peek_r(3'd3, v);
        chk("R7 old memory used", v, 32'd21);
        peek_m(8'h20, v);
        chk("R7 memory written", v, 32'h99);

        // R5: index displacements and wrap
        load(2'd2, 8'd0, 32'h05);
        load(2'd2, 8'd1, 32'h0A);
        load(2'd1, 8'd2, 32'h30);
        load(2'd3, 8'h35, 32'd2);
        load(2'd0, 8'd1, 32'd9);
        load(2'd0, 8'd2, 32'hCAFE);
        run(3'd1, 3'd3, 3'd2, 3'd2, 2'd2, 3'd2, 2'd3);
        peek_r(3'd3, v);
        chk("R5 index0 read", v, 32'd18);
        peek_m(8'h3A, v);
        chk("R5 index1 write", v, 32'hCAFE);
        load(2'd1, 8'd3, 32'hFF);
        load(2'd3, 8'h00, 32'd4);
        load(2'd0, 8'd2, 32'hBEEF);
        run(3'd1, 3'd3, 3'd2, 3'd3, 2'd1, 3'd3, 2'd1);
        peek_r(3'd3, v);
        chk("R5 wrap read", v, 32'd36);
        peek_m(8'h00, v);
        chk("R5 wrap write", v, 32'hBEEF);

        // R8: load alongside an issue is ignored
        load(2'd0, 8'd5, 32'h1234);
        ld_en = 1; ld_space = 2'd0; ld_idx = 8'd5; ld_data = 32'hDEAD;
        run(3'd1, 3'd3, 3'd2, 3'd3, 2'd1, 3'd3, 2'd1);
        ld_en = 0;
        peek_r(3'd5, v);
        chk("R8 load ignored", v, 32'h1234);

        report();
    end
endmodule